// File: doc/BRIEF.md
# Microwire Serial EEPROM Host Controller

This block is the master side of a three-wire serial link to a 64-word by 16-bit EEPROM. A request port takes an instruction, a 6-bit word address and a 16-bit write word. The engine then drives chip select, serial clock and serial data out. It shifts out a start bit, a two-bit opcode and an address field. It adds sixteen data bits when the instruction carries data, and collects sixteen read bits when the instruction is a read. When the engine finishes, it pulses `done` for one cycle and returns to idle.

Programming instructions (word write, word erase, erase-all, write-all) end with a busy poll. The engine drops chip select for the minimum low time and raises it again with the serial clock parked low. It then watches the memory's data line until the line reads high. A poll limit guards against a memory that never becomes ready. Each serial clock phase lasts a parameterised number of system clocks. The serial clock may stall between bits, so the engine adds no further pacing.

Top module: `uwire_host`

## Requirements
- R1: Every frame starts with DI=1 on the first rising CLK, then a 2-bit opcode and a 6-bit address field, MSB first. The reqOp codes and what is sent are: 0 read → 10+addr; 1 write → 01+addr; 2 erase → 11+addr; 3 write-enable → 00+110000; 4 erase-all → 00+100000; 5 write-all → 00+010000; 6 write-disable → 00+000000.
- R2: A read, write or write-all frame has exactly 25 CLK rising edges, and the other instructions have 9. In write and write-all frames, clocks 10 to 25 carry reqWdata MSB first.
- R3: Each CLK high phase lasts exactly HALF_DIV system clocks, and each low phase inside a frame lasts at least HALF_DIV. DI changes only while CLK is low.
- R4: For a read, the dummy bit after clock 9 is skipped. DO is sampled at the end of the high phase of clocks 10 to 25 and shifted MSB first into rdData, which is valid while done is high.
- R5: Between any two CS-high intervals, and between reset and the first one, CS stays low for at least CS_GAP system clocks.
- R6: After each programming frame, CS stays low for the gap and then rises once more with CLK low. The engine holds CS high until DO reads 1, then drops CS, waits the gap and pulses done with err=0.
- R7: If DO stays 0 for POLL_LIMIT consecutive poll cycles, CS drops, and done is then pulsed with err=1.
- R8: reqReady is high only while idle. A reqValid during an operation is ignored and starts no frame.
- R9: done is a one-cycle pulse, and err is never high without done.
- R10: While and after reset, CS, CLK and DI are low, done and err are low and reqReady is high.
- R11: CLK rises only while CS is high, and it is low outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start request, taken when reqReady is high |
| reqOp | input | 3 | Instruction code (see R1) |
| reqAddr | input | 6 | Word address |
| reqWdata | input | 16 | Write word |
| reqReady | output | 1 | Engine idle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout, valid with done |
| rdData | output | 16 | Read word |
| memCs | output | 1 | Chip select to memory |
| memClk | output | 1 | Serial clock to memory |
| memDi | output | 1 | Serial data to memory |
| memDo | input | 1 | Serial data and ready status from memory |

## Verification
The bench drives a behavioural memory with a write-enable latch and a busy countdown. It checks that data lands, and that a write issued while writes are disabled has no effect. This catches a design that swaps the prefix bits of the two-zero-opcode group. Read-back after erase and write-all catches a read off by one bit position, which would show up as a word shifted by one with the dummy zero at the top. A memory held busy forces the poll limit: a design with an off-by-one limit holds CS high for the wrong number of cycles, and one that forgets the error flag reports success. A request pulsed during a read is expected to start no second frame.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_WREN      = 3'd3,
    OP_ERASEALL  = 3'd4,
    OP_WRITEALL  = 3'd5,
    OP_WRDIS     = 3'd6
  } uwOp_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic phaseRst;
    logic bitEnd;
    logic waitRst;
  } uwStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic phaseEnd;
    logic lastBit;
    logic gapDone;
    logic pollExpired;
    logic isProg;
  } uwStatus_t;

  function automatic logic isProgOp(input logic [2:0] op);
    return op inside {OP_WRITE, OP_ERASE, OP_ERASEALL, OP_WRITEALL};
  endfunction

  function automatic logic isLongOp(input logic [2:0] op);
    return op inside {OP_READ, OP_WRITE, OP_WRITEALL};
  endfunction

endpackage

// File: rtl/uwire_dpath.sv
module uwire_dpath
  import uwire_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int HALF_DIV   = 2,
  parameter int CS_GAP     = 13,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  uwStrobe_t         strobe,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              memDo,
  output uwStatus_t         status,
  output logic              memDi,
  output logic [DATA_W-1:0] rdData
);
  localparam int CMD_LEN  = 3 + ADDR_W;
  localparam int LONG_LEN = CMD_LEN + DATA_W;
  localparam int CNT_W    = $clog2(LONG_LEN + 1);
  localparam int PH_W     = $clog2(HALF_DIV + 1);
  localparam int WAIT_MAX = (CS_GAP > POLL_LIMIT) ? CS_GAP : POLL_LIMIT;
  localparam int WT_W     = $clog2(WAIT_MAX + 1);

  logic [LONG_LEN-1:0] frameReg, frameNext;
  logic [CNT_W-1:0]    bitsLeft;
  logic [PH_W-1:0]     phaseCnt;
  logic [WT_W-1:0]     waitCnt;
  logic [2:0]          opReg;
  logic [DATA_W-1:0]   rdShift;
  logic [1:0]          opBits;
  logic [ADDR_W-1:0]   addrBits;

  // frame image: start bit, opcode, address field, data (zero unless written)
  always_comb begin
    opBits   = 2'b00;
    addrBits = reqAddr;
    unique case (reqOp)
      OP_READ:      opBits = 2'b10;
      OP_WRITE:     opBits = 2'b01;
      OP_ERASE:     opBits = 2'b11;
      OP_WREN:      addrBits = {2'b11, {(ADDR_W-2){1'b0}}};
      OP_ERASEALL:  addrBits = {2'b10, {(ADDR_W-2){1'b0}}};
      OP_WRITEALL:  addrBits = {2'b01, {(ADDR_W-2){1'b0}}};
      default:      addrBits = '0;
    endcase
    frameNext = {1'b1, opBits, addrBits,
                 (reqOp inside {OP_WRITE, OP_WRITEALL}) ? reqWdata : {DATA_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      bitsLeft <= '0;
      opReg    <= '0;
    end else if (strobe.load) begin
      frameReg <= frameNext;
      bitsLeft <= isLongOp(reqOp) ? CNT_W'(LONG_LEN) : CNT_W'(CMD_LEN);
      opReg    <= reqOp;
    end else if (strobe.bitEnd) begin
      frameReg <= {frameReg[LONG_LEN-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      phaseCnt <= '0;
    else if (strobe.phaseRst)       phaseCnt <= '0;
    else if (!status.phaseEnd)      phaseCnt <= phaseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              waitCnt <= '0;
    else if (strobe.waitRst)                waitCnt <= '0;
    else if (waitCnt != WT_W'(WAIT_MAX))    waitCnt <= waitCnt + 1'b1;
  end

  // read capture: last DATA_W clocks of a read frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdShift <= '0;
    else if (strobe.bitEnd && opReg == OP_READ && bitsLeft <= CNT_W'(DATA_W))
      rdShift <= {rdShift[DATA_W-2:0], memDo};
  end

  assign status.phaseEnd    = (phaseCnt == PH_W'(HALF_DIV - 1));
  assign status.lastBit     = (bitsLeft == CNT_W'(1));
  assign status.gapDone     = (waitCnt == WT_W'(CS_GAP - 1));
  assign status.pollExpired = (waitCnt == WT_W'(POLL_LIMIT - 1));
  assign status.isProg      = isProgOp(opReg);
  assign memDi              = frameReg[LONG_LEN-1];
  assign rdData             = rdShift;

endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
  import uwire_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memDo,
  input  uwStatus_t status,
  output uwStrobe_t strobe,
  output logic      memCs,
  output logic      memClk,
  output logic      reqReady,
  output logic      done,
  output logic      err
);
  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_GAP, S_POLL, S_FIN} state_e;

  state_e state, nextState;
  logic   polled, errFlag;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strobe.load     = 1'b1;
        strobe.phaseRst = 1'b1;
        nextState       = S_LO;
      end
      S_LO: if (status.phaseEnd) begin
        strobe.phaseRst = 1'b1;
        nextState       = S_HI;
      end
      S_HI: if (status.phaseEnd) begin
        strobe.phaseRst = 1'b1;
        strobe.bitEnd   = 1'b1;
        if (status.lastBit) begin
          strobe.waitRst = 1'b1;
          nextState      = S_GAP;
        end else begin
          nextState = S_LO;
        end
      end
      S_GAP: if (status.gapDone) begin
        strobe.waitRst = 1'b1;
        nextState      = (status.isProg && !polled) ? S_POLL : S_FIN;
      end
      S_POLL: if (memDo || status.pollExpired) begin
        strobe.waitRst = 1'b1;
        nextState      = S_GAP;
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      polled  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_FIN) begin
        polled  <= 1'b0;
        errFlag <= 1'b0;
      end else begin
        if (state == S_GAP && nextState == S_POLL) polled <= 1'b1;
        if (state == S_POLL && !memDo && status.pollExpired) errFlag <= 1'b1;
      end
    end
  end

  assign memCs    = (state == S_LO) || (state == S_HI) || (state == S_POLL);
  assign memClk   = (state == S_HI);
  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_FIN);
  assign err      = (state == S_FIN) && errFlag;

endmodule

// File: rtl/uwire_host.sv
module uwire_host
  import uwire_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int HALF_DIV   = 2,
  parameter int CS_GAP     = 13,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdData,
  output logic              memCs,
  output logic              memClk,
  output logic              memDi,
  input  logic              memDo
);
  uwStrobe_t strobe;
  uwStatus_t status;

  uwire_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memDo    (memDo),
    .status   (status),
    .strobe   (strobe),
    .memCs    (memCs),
    .memClk   (memClk),
    .reqReady (reqReady),
    .done     (done),
    .err      (err)
  );

  uwire_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .HALF_DIV   (HALF_DIV),
    .CS_GAP     (CS_GAP),
    .POLL_LIMIT (POLL_LIMIT)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDo    (memDo),
    .status   (status),
    .memDi    (memDi),
    .rdData   (rdData)
  );

endmodule

// File: rtl/uwire_host_chk.sv
module uwire_host_chk #(
  parameter int CS_GAP = 13
) (
  input logic clk,
  input logic rstN,
  input logic memCs,
  input logic memClk,
  input logic memDi,
  input logic reqReady,
  input logic done,
  input logic err
);
  localparam int LC_W = $clog2(CS_GAP + 1);

  // consecutive CS-low cycles, saturating; reset counts as a long low time
  logic [LC_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lowCnt <= LC_W'(CS_GAP);
    else if (memCs)                     lowCnt <= '0;
    else if (lowCnt != LC_W'(CS_GAP))   lowCnt <= lowCnt + 1'b1;
  end

  assert_clk_in_frame_R11: assert property (@(posedge clk) disable iff (!rstN)
    memClk |-> memCs);

  assert_di_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memClk && $past(memClk)) |-> $stable(memDi));

  assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCs) |-> (lowCnt >= LC_W'(CS_GAP)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    memCs |-> !reqReady);

endmodule

bind uwire_host uwire_host_chk #(.CS_GAP(CS_GAP)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memCs    (memCs),
  .memClk   (memClk),
  .memDi    (memDi),
  .reqReady (reqReady),
  .done     (done),
  .err      (err)
);

// File: tb/test_uwire_host.sv
module test_uwire_host;
  import uwire_pkg::*;

  localparam int HALF_DIV   = 2;
  localparam int CS_GAP     = 13;
  localparam int POLL_LIMIT = 200;
  localparam int BUSY_CYC   = 40;
  localparam int WD_LIMIT   = 150000;
  localparam int NVEC       = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [5:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, done, err, memCs, memClk, memDi, memDo;
  logic [15:0] rdData;

  always #10 clk = ~clk;  // 50 MHz

  uwire_host #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) i_uwire_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqReady(reqReady), .done(done), .err(err), .rdData(rdData),
    .memCs(memCs), .memClk(memClk), .memDi(memDi), .memDo(memDo));

  // ---------------- behavioural memory ----------------
  logic [15:0] mem [64];
  logic prevCs, prevClk, prevDi, started, reading, dataOp, allOp, progPend, wen, doReg, stuck;
  logic [7:0] cmd;
  logic [15:0] dat;
  logic [24:0] frameBits, lastFrame;
  int bitCnt, rdIdx, busy, lowLen, hiLen, csHiLen, lastHiLen, clkCount, lastClks;
  int csRises, gapErr, phaseErr, protoErr;

  initial stuck = 1'b0;

  assign memDo = reading ? doReg : (memCs && busy == 0 && !stuck);

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
      prevCs = 0; prevClk = 0; prevDi = 0; started = 0; reading = 0; dataOp = 0; allOp = 0;
      progPend = 0; wen = 0; doReg = 0; cmd = 0; dat = 0; frameBits = 0; lastFrame = 0;
      bitCnt = 0; rdIdx = 15; busy = 0; lowLen = 1000; hiLen = 0; csHiLen = 0; lastHiLen = 0;
      clkCount = 0; lastClks = 0; csRises = 0; gapErr = 0; phaseErr = 0; protoErr = 0;
    end else begin
      if (busy > 0) busy--;
      if (memClk && !memCs) protoErr++;
      if (memCs && !prevCs) begin
        csRises++;
        if (lowLen < CS_GAP) gapErr++;
        started = 0; reading = 0; dataOp = 0; allOp = 0; bitCnt = 0;
        csHiLen = 0; clkCount = 0; frameBits = 0;
      end
      if (!memCs && prevCs) begin
        lastHiLen = csHiLen;
        lowLen = 0;
        reading = 0;
        if (clkCount > 0) begin lastClks = clkCount; lastFrame = frameBits; end
        if (progPend) begin busy = BUSY_CYC; progPend = 0; end
      end
      if (memCs) csHiLen++; else lowLen++;
      if (memClk) hiLen++;
      if (!memClk && prevClk) begin
        if (hiLen != HALF_DIV) phaseErr++;
        hiLen = 0;
      end
      if (memClk && prevClk && memDi != prevDi) phaseErr++;
      if (memCs && memClk && !prevClk) begin
        clkCount++;
        frameBits = {frameBits[23:0], memDi};
        if (!started) begin
          if (memDi) begin started = 1; bitCnt = 0; end
        end else if (bitCnt < 8) begin
          cmd = {cmd[6:0], memDi};
          bitCnt++;
          if (bitCnt == 8) begin
            case (cmd[7:6])
              2'b10: begin reading = 1; doReg = 0; rdIdx = 15; end
              2'b01: dataOp = 1;
              2'b11: begin if (wen) mem[cmd[5:0]] = 16'hFFFF; progPend = wen; end
              default: case (cmd[5:4])
                2'b11: wen = 1;
                2'b00: wen = 0;
                2'b10: begin
                  if (wen) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                  progPend = wen;
                end
                default: begin dataOp = 1; allOp = 1; end
              endcase
            endcase
          end
        end else if (reading) begin
          doReg = mem[cmd[5:0]][rdIdx];
          rdIdx--;
        end else if (dataOp && bitCnt < 24) begin
          dat = {dat[14:0], memDi};
          bitCnt++;
          if (bitCnt == 24 && wen) begin
            if (allOp) for (int i = 0; i < 64; i++) mem[i] = dat;
            else mem[cmd[5:0]] = dat;
            progPend = 1;
          end
        end
      end
      prevCs = memCs; prevClk = memClk; prevDi = memDi;
    end
  end

  // ---------------- checking ----------------
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic gotErr;
  logic [15:0] gotRd;
  int riseBase;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      compared++; mismatched++;
      $display("FAIL R9 watchdog actual=no_done expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [8:0] header(input logic [2:0] op, input logic [5:0] a);
    case (op)
      OP_READ:     return {3'b110, a};
      OP_WRITE:    return {3'b101, a};
      OP_ERASE:    return {3'b111, a};
      OP_WREN:     return 9'b100110000;
      OP_ERASEALL: return 9'b100100000;
      OP_WRITEALL: return 9'b100010000;
      default:     return 9'b100000000;
    endcase
  endfunction

  task automatic runOp(input logic [2:0] op, input logic [5:0] a, input logic [15:0] wd);
    riseBase = csRises;
    @(negedge clk);
    reqValid = 1; reqOp = op; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    while (!done) @(negedge clk);
    gotErr = err;
    gotRd = rdData;
    @(negedge clk);
    check(!done, "R9 done width", int'(done), 0);
  endtask

  // {op, addr, wdata, expected read, expected clocks}
  localparam logic [45:0] VEC [NVEC] = '{
    {OP_WREN,      6'd0,  16'h0000, 16'h0000, 5'd9},
    {OP_WRITE,     6'd5,  16'h1234, 16'h0000, 5'd25},
    {OP_READ,      6'd5,  16'h0000, 16'h1234, 5'd25},
    {OP_WRITE,     6'd63, 16'hABCD, 16'h0000, 5'd25},
    {OP_READ,      6'd63, 16'h0000, 16'hABCD, 5'd25},
    {OP_ERASE,     6'd5,  16'h0000, 16'h0000, 5'd9},
    {OP_READ,      6'd5,  16'h0000, 16'hFFFF, 5'd25},
    {OP_WRDIS,     6'd0,  16'h0000, 16'h0000, 5'd9},
    {OP_WRITE,     6'd7,  16'h5555, 16'h0000, 5'd25},
    {OP_READ,      6'd7,  16'h0000, 16'hFFFF, 5'd25},
    {OP_WREN,      6'd0,  16'h0000, 16'h0000, 5'd9},
    {OP_WRITEALL,  6'd0,  16'h0F0F, 16'h0000, 5'd25},
    {OP_READ,      6'd0,  16'h0000, 16'h0F0F, 5'd25},
    {OP_ERASEALL,  6'd0,  16'h0000, 16'h0000, 5'd9},
    {OP_READ,      6'd40, 16'h0000, 16'hFFFF, 5'd25}
  };

  initial begin
    repeat (3) @(negedge clk);
    check(!memCs && !memClk && !memDi, "R10 pins in reset", {memCs, memClk, memDi}, 0);
    check(reqReady && !done && !err, "R10 flags in reset", {reqReady, done, err}, 3'b100);
    rstN = 1;
    @(negedge clk);
    check(!memCs && !memClk && !memDi && reqReady && !done, "R10 after reset",
          {memCs, memClk, memDi, reqReady, done}, 5'b00010);

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] op;
      logic [5:0] a;
      logic [15:0] wd, ex;
      int clks;
      op = VEC[v][45:43]; a = VEC[v][42:37]; wd = VEC[v][36:21]; ex = VEC[v][20:5];
      clks = int'(VEC[v][4:0]);
      runOp(op, a, wd);
      check(!gotErr, "R6 err clear", int'(gotErr), 0);
      check(lastClks == clks, "R2 clock count", lastClks, clks);
      check(lastFrame[lastClks-1 -: 9] == header(op, a), "R1 header",
            int'(lastFrame[lastClks-1 -: 9]), int'(header(op, a)));
      if (op == OP_WRITE || op == OP_WRITEALL)
        check(lastFrame[15:0] == wd, "R2 data bits", int'(lastFrame[15:0]), int'(wd));
      if (op == OP_READ)
        check(gotRd == ex, "R4 read word", int'(gotRd), int'(ex));
      check((csRises - riseBase) == (isProgOp(op) ? 2 : 1), "R6 CS intervals",
            csRises - riseBase, isProgOp(op) ? 2 : 1);
    end

    // R8: request during a busy read is ignored
    riseBase = csRises;
    @(negedge clk);
    reqValid = 1; reqOp = OP_READ; reqAddr = 6'd5; reqWdata = 0;
    @(negedge clk);
    reqValid = 0;
    repeat (20) @(negedge clk);
    check(!reqReady, "R8 ready low while busy", int'(reqReady), 0);
    reqValid = 1; reqOp = OP_WRITE; reqAddr = 6'd5; reqWdata = 16'h0000;
    @(negedge clk);
    reqValid = 0;
    while (!done) @(negedge clk);
    check(rdData == 16'hFFFF, "R8 read unaffected", int'(rdData), 16'hFFFF);
    repeat (30) @(negedge clk);
    check(csRises - riseBase == 1, "R8 no extra frame", csRises - riseBase, 1);
    runOp(OP_READ, 6'd5, 16'h0);
    check(gotRd == 16'hFFFF, "R8 write ignored", int'(gotRd), 16'hFFFF);

    // R7: memory stuck busy
    stuck = 1;
    runOp(OP_WRITE, 6'd2, 16'h1111);
    check(gotErr, "R7 timeout err", int'(gotErr), 1);
    check(lastHiLen == POLL_LIMIT, "R7 poll length", lastHiLen, POLL_LIMIT);
    check(!memCs && reqReady, "R7 idle CS low", {memCs, reqReady}, 2'b01);
    stuck = 0;
    runOp(OP_ERASE, 6'd2, 16'h0);
    check(!gotErr, "R6 recovers after timeout", int'(gotErr), 0);

    check(phaseErr == 0, "R3 phase/DI violations", phaseErr, 0);
    check(gapErr == 0, "R5 CS gap violations", gapErr, 0);
    check(protoErr == 0, "R11 CLK outside CS", protoErr, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule